// File: doc/BRIEF.md
# Dual-Host Secondary Interrupt Stage

This block gathers a set of interrupt sources for one peripheral and reports them to two host masters at once. Every source input is synchronised and passed through an edge qualifier. A per-source two-bit field selects rising edges, falling edges, both, or neither. A qualifying event is latched into two independent status banks, one per host. Each bank has its own mask, its own test-set register and its own registered, active-low interrupt output. A host therefore sees, acknowledges and masks its own copy of every event without disturbing the other host.

A shared control byte sets the acknowledge policy for both banks. In one policy a status byte clears when it is read. In the other, status bits clear only when ones are written to them. The control byte also sets whether a second event on an already-pending source is buffered and replayed after the acknowledge. All access goes through a plain byte-wide register port, with reads returned one cycle after the strobe. The port carries no streamed data, so it uses single-cycle strobes with no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `irq_sih_dual`

## Requirements
- R1: After reset, every status bit is 0, every mask bit is 1 (mask byte bits above the last source read 0), the control byte is 0, and both `irq_n` bits are 1.
- R2: The edge field resets to 0. A source whose two edge bits are both 0 never latches status in either bank.
- R3: Edge bit 2i enables rising-edge capture for source i. A rising edge reaches both banks' status two clock edges after the input's first sampling edge.
- R4: Edge bit 2i+1 enables falling-edge capture for source i, in both banks.
- R5: A masked source still latches status. When every mask bit of a bank is 1, that bank's `irq_n` is 1 on the next cycle.
- R6: `irq_n[b]` goes low one cycle after any bit of bank b is both set and unmasked. Bank 0 and bank 1 drive their outputs independently.
- R7: With control bit 0 (clear-on-read) at 0, reading a status byte leaves it unchanged, and writing a 1 to a status bit clears it.
- R8: With control bit 0 at 1, reading a status byte clears the bits it returned, and writes to status bytes have no effect.
- R9: With control bit 1 (pending-disable) at 0, an event on a source whose status bit is already set is held. When the bit is next cleared, it stays set once more. With control bit 1 at 1, such an event is dropped.
- R10: Writing a 1 to a bit of bank b's test-set byte sets that status bit in bank b only. Test-set bytes read as 0.
- R11: When a clear and a new qualifying event hit the same status bit in the same cycle, the bit remains set.
- R12: The byte map is as follows (shown for 12 sources):
  - 0: control
  - 1–3: edge field, source i in bits 2i and 2i+1
  - 4–5: bank 0 status
  - 6–7: bank 0 mask
  - 8–9: bank 1 status
  - 10–11: bank 1 mask
  - 12–13: bank 0 test-set
  - 14–15: bank 1 test-set

  `rdata` carries the addressed byte in the cycle after `rd_en` and is 0 otherwise. The edge field keeps its written value through every clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N | Asynchronous interrupt source levels |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq_n | output | 2 | Active-low interrupt, one per host bank |

## Verification
Faults in this block appear at the ports within a few cycles. A stuck or lost status bit shows up on the next status read and, if that bit is unmasked, on `irq_n` one cycle later. A wrong pending bit stays hidden until the acknowledge: the next read then returns the bit set when it should be clear, or clear when it should be set. A swapped bank or a misdecoded byte shows up as the other host's output moving. The bench therefore runs a behavioural model in step with the design and compares `rdata` and `irq_n` on every clock. It also places directed checks around each acknowledge.

// File: rtl/irq_sih_pkg.sv
package irq_sih_pkg;
  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction

  typedef struct packed {
    logic pend_dis;
    logic cor;
  } sih_ctrl_t;
endpackage

// File: rtl/irq_sih_edge.sv
module irq_sih_edge #(
  parameter int N = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src_i,
  input  logic [2*N-1:0] edge_sel_i,
  output logic [N-1:0]   evt_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] en_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    assign evt_o[i]  = (sync_q[i] & ~prev_q[i] & edge_sel_i[2*i])
                     | (~sync_q[i] & prev_q[i] & edge_sel_i[2*i+1]);
    assign en_any[i] = edge_sel_i[2*i] | edge_sel_i[2*i+1];
  end

  // R2: a source with no edge enabled never produces an event
  a_r2_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & ~en_any) == '0);
endmodule

// File: rtl/irq_sih_bank.sv
module irq_sih_bank #(
  parameter int N  = 12,
  parameter int SB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic          cor_i,
  input  logic          pend_dis_i,
  input  logic [SB-1:0] st_rd_i,
  input  logic [SB-1:0] st_wr_i,
  input  logic [SB-1:0] mk_wr_i,
  input  logic [SB-1:0] ts_wr_i,
  input  logic [7:0]    wdata_i,
  output logic [N-1:0]  status_o,
  output logic [N-1:0]  mask_o,
  output logic          irq_n_o
);
  logic [N-1:0] st_q, pd_q, mk_q;
  logic [N-1:0] st_d, pd_d, mk_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int BY = i / 8;
    localparam int BI = i % 8;
    logic clr, tset;
    assign clr  = cor_i ? st_rd_i[BY] : (st_wr_i[BY] & wdata_i[BI]);
    assign tset = ts_wr_i[BY] & wdata_i[BI];
    assign st_d[i] = evt_i[i] | tset | (st_q[i] & ~clr) | (clr & pd_q[i]);
    assign pd_d[i] = clr ? 1'b0 : (pd_q[i] | (st_q[i] & evt_i[i] & ~pend_dis_i));
    assign mk_d[i] = mk_wr_i[BY] ? wdata_i[BI] : mk_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      pd_q    <= '0;
      mk_q    <= '1;
      irq_n_o <= 1'b1;
    end else begin
      st_q    <= st_d;
      pd_q    <= pd_d;
      mk_q    <= mk_d;
      irq_n_o <= ~|(st_q & ~mk_q);
    end
  end

  assign status_o = st_q;
  assign mask_o   = mk_q;

  // R6: an unmasked pending bit pulls the line low on the next cycle
  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_q & ~mk_q)) |=> !irq_n_o);
  // R5: a fully masked bank keeps its line high
  a_r5_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (&mk_q) |=> irq_n_o);
  // R11: a fresh event always leaves its status bit set
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((st_q & $past(evt_i)) == $past(evt_i)));
  // R9: a held event only exists behind a set status bit
  a_r9_pend_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q & ~st_q) == '0);
endmodule

// File: rtl/irq_sih_dual.sv
module irq_sih_dual
  import irq_sih_pkg::*;
#(
  parameter int N  = 12,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [1:0]    irq_n
);
  localparam int SB       = bytes_for(N);
  localparam int EB       = bytes_for(2 * N);
  localparam int OFF_CTRL = 0;
  localparam int OFF_EDGE = 1;
  localparam int OFF_ST0  = OFF_EDGE + EB;
  localparam int OFF_MK0  = OFF_ST0 + SB;
  localparam int OFF_ST1  = OFF_MK0 + SB;
  localparam int OFF_MK1  = OFF_ST1 + SB;
  localparam int OFF_TS0  = OFF_MK1 + SB;
  localparam int OFF_TS1  = OFF_TS0 + SB;

  sih_ctrl_t        ctrl_q;
  logic [8*EB-1:0]  edge_q;
  logic [N-1:0]     evt;
  logic [N-1:0]     st [2];
  logic [N-1:0]     mk [2];
  logic [SB-1:0]    st_rd [2];
  logic [SB-1:0]    st_wr [2];
  logic [SB-1:0]    mk_wr [2];
  logic [SB-1:0]    ts_wr [2];
  logic [8*SB-1:0]  st_p [2];
  logic [8*SB-1:0]  mk_p [2];
  logic [7:0]       rsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      edge_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en && addr == AW'(OFF_CTRL)) ctrl_q <= sih_ctrl_t'(wdata[1:0]);
      for (int j = 0; j < EB; j++)
        if (wr_en && addr == AW'(OFF_EDGE + j)) edge_q[8*j +: 8] <= wdata;
      rdata <= rd_en ? rsel : 8'h00;
    end
  end

  irq_sih_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .edge_sel_i(edge_q[2*N-1:0]), .evt_o(evt)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int SOFF = (b == 0) ? OFF_ST0 : OFF_ST1;
    localparam int MOFF = (b == 0) ? OFF_MK0 : OFF_MK1;
    localparam int TOFF = (b == 0) ? OFF_TS0 : OFF_TS1;
    for (genvar j = 0; j < SB; j++) begin : g_dec
      assign st_rd[b][j] = rd_en && (addr == AW'(SOFF + j));
      assign st_wr[b][j] = wr_en && (addr == AW'(SOFF + j));
      assign mk_wr[b][j] = wr_en && (addr == AW'(MOFF + j));
      assign ts_wr[b][j] = wr_en && (addr == AW'(TOFF + j));
    end
    always_comb begin
      st_p[b] = '0;
      mk_p[b] = '0;
      st_p[b][N-1:0] = st[b];
      mk_p[b][N-1:0] = mk[b];
    end
    irq_sih_bank #(.N(N), .SB(SB)) u_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(evt),
      .cor_i(ctrl_q.cor), .pend_dis_i(ctrl_q.pend_dis),
      .st_rd_i(st_rd[b]), .st_wr_i(st_wr[b]), .mk_wr_i(mk_wr[b]),
      .ts_wr_i(ts_wr[b]), .wdata_i(wdata),
      .status_o(st[b]), .mask_o(mk[b]), .irq_n_o(irq_n[b])
    );
  end

  always_comb begin
    rsel = 8'h00;
    if (addr == AW'(OFF_CTRL)) rsel = {6'b0, ctrl_q};
    for (int j = 0; j < EB; j++)
      if (addr == AW'(OFF_EDGE + j)) rsel = edge_q[8*j +: 8];
    for (int j = 0; j < SB; j++) begin
      if (addr == AW'(OFF_ST0 + j)) rsel = st_p[0][8*j +: 8];
      if (addr == AW'(OFF_MK0 + j)) rsel = mk_p[0][8*j +: 8];
      if (addr == AW'(OFF_ST1 + j)) rsel = st_p[1][8*j +: 8];
      if (addr == AW'(OFF_MK1 + j)) rsel = mk_p[1][8*j +: 8];
    end
  end

  // R12: read data is zero in any cycle not following a read strobe
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 8'h00));
  // R12: the edge field is untouched by anything but its own writes
  a_r12_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr >= AW'(OFF_EDGE) && addr < AW'(OFF_EDGE + EB)) |=> $stable(edge_q));
endmodule

// File: tb/irq_sih_dual_bench.sv
module irq_sih_dual_bench;
  localparam int N  = 12;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [1:0]    irq_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_sih_dual #(.N(N), .AW(AW)) u_irq_sih_dual (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // ---------------- behavioural reference model ----------------
  logic [N-1:0]   m_s1, m_s2, m_s3;
  logic [N-1:0]   m_st [2];
  logic [N-1:0]   m_pd [2];
  logic [N-1:0]   m_mk [2];
  logic [23:0]    m_ed;
  logic           m_cor, m_pdis;
  logic [7:0]     m_rd;
  logic [1:0]     m_irq;

  function automatic logic [7:0] m_read(input int a);
    logic [15:0] s0, s1, k0, k1;
    s0 = 16'(m_st[0]); s1 = 16'(m_st[1]);
    k0 = 16'(m_mk[0]); k1 = 16'(m_mk[1]);
    case (a)
      0: return {6'b0, m_pdis, m_cor};
      1, 2, 3: return m_ed[8*(a-1) +: 8];
      4, 5: return s0[8*(a-4) +: 8];
      6, 7: return k0[8*(a-6) +: 8];
      8, 9: return s1[8*(a-8) +: 8];
      10, 11: return k1[8*(a-10) +: 8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] ev;
    logic [N-1:0] nst [2];
    logic [N-1:0] npd [2];
    logic [N-1:0] nmk [2];
    logic [1:0]   nirq;
    logic [7:0]   nrd;
    int a;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      for (int b = 0; b < 2; b++) begin
        m_st[b] = '0; m_pd[b] = '0; m_mk[b] = '1;
      end
      m_ed = '0; m_cor = 0; m_pdis = 0; m_rd = 0; m_irq = 2'b11;
    end else begin
      a = int'(addr);
      for (int i = 0; i < N; i++)
        ev[i] = (m_s2[i] && !m_s3[i] && m_ed[2*i]) || (!m_s2[i] && m_s3[i] && m_ed[2*i+1]);
      nrd = rd_en ? m_read(a) : 8'h00;
      for (int b = 0; b < 2; b++) begin
        nirq[b] = ((m_st[b] & ~m_mk[b]) == '0);
        for (int i = 0; i < N; i++) begin
          int sa, ta, ma;
          logic clr, ts;
          sa = (b == 0 ? 4 : 8) + i / 8;
          ma = (b == 0 ? 6 : 10) + i / 8;
          ta = (b == 0 ? 12 : 14) + i / 8;
          clr = m_cor ? (rd_en && a == sa) : (wr_en && a == sa && wdata[i % 8]);
          ts  = wr_en && a == ta && wdata[i % 8];
          nst[b][i] = ev[i] || ts || (m_st[b][i] && !clr) || (clr && m_pd[b][i]);
          npd[b][i] = clr ? 1'b0 : (m_pd[b][i] || (m_st[b][i] && ev[i] && !m_pdis));
          nmk[b][i] = (wr_en && a == ma) ? wdata[i % 8] : m_mk[b][i];
        end
      end
      if (wr_en && a == 0) begin m_cor = wdata[0]; m_pdis = wdata[1]; end
      if (wr_en && a >= 1 && a <= 3) m_ed[8*(a-1) +: 8] = wdata;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src_i;
      for (int b = 0; b < 2; b++) begin
        m_st[b] = nst[b]; m_pd[b] = npd[b]; m_mk[b] = nmk[b];
      end
      m_rd = nrd; m_irq = nirq;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== m_rd || irq_n !== m_irq) begin
        errors++;
        $display("FAIL R12/R6 model: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
                 rdata, irq_n, m_rd, m_irq);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); d = rdata; rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk); src_i[i] = v;
    idle(4);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 irq_n", {6'b0, irq_n}, 8'h03);
    rd(6, v);  chk("R1 mask0 byte0", v, 8'hFF);
    rd(7, v);  chk("R1 mask0 byte1 padding", v, 8'h0F);
    rd(4, v);  chk("R1 status0", v, 8'h00);
    rd(0, v);  chk("R1 control", v, 8'h00);
    // R2 no edge selected
    set_src(0, 1);
    rd(4, v);  chk("R2 no trigger bank0", v, 8'h00);
    rd(8, v);  chk("R2 no trigger bank1", v, 8'h00);
    set_src(0, 0);
    // R3 rising edge, both banks
    wr(1, 8'h01);
    set_src(0, 1);
    rd(4, v);  chk("R3 rise bank0", v, 8'h01);
    rd(8, v);  chk("R3 rise bank1", v, 8'h01);
    // R5 masked still latched, no output
    chk("R5 masked irq_n", {6'b0, irq_n}, 8'h03);
    // R6 unmask bank0 only
    wr(6, 8'hFE); idle(1);
    chk("R6 bank0 low bank1 high", {6'b0, irq_n}, 8'h02);
    // R7 read does not clear, write one clears
    rd(4, v);  chk("R7 read keeps", v, 8'h01);
    rd(4, v);  chk("R7 read keeps again", v, 8'h01);
    wr(4, 8'h01);
    rd(4, v);  chk("R7 write clears", v, 8'h00);
    chk("R6 released", {6'b0, irq_n}, 8'h03);
    // R4 falling edge
    wr(1, 8'h02);
    set_src(0, 0);
    rd(4, v);  chk("R4 fall bank0", v, 8'h01);
    // R8 clear on read
    wr(0, 8'h01);
    rd(4, v);  chk("R8 cor first read", v, 8'h01);
    rd(4, v);  chk("R8 cor cleared", v, 8'h00);
    wr(12, 8'h01);
    wr(4, 8'h01);
    rd(4, v);  chk("R8 write ignored", v, 8'h01);
    rd(4, v);  chk("R8 cleared by read", v, 8'h00);
    // R9 bank1 bit0 held a second event (rise then fall)
    rd(8, v);  chk("R9 bank1 first", v, 8'h01);
    rd(8, v);  chk("R9 bank1 replay", v, 8'h01);
    rd(8, v);  chk("R9 bank1 empty", v, 8'h00);
    // R9 pending on source 1, both edges
    wr(1, 8'h0C);
    set_src(1, 1);
    set_src(1, 0);
    rd(4, v);  chk("R9 pend first", v, 8'h02);
    rd(4, v);  chk("R9 pend replay", v, 8'h02);
    rd(4, v);  chk("R9 pend drained", v, 8'h00);
    rd(8, v); rd(8, v); rd(8, v);
    // R9 pending disabled
    wr(0, 8'h03);
    set_src(1, 1);
    set_src(1, 0);
    rd(4, v);  chk("R9 pdis first", v, 8'h02);
    rd(4, v);  chk("R9 pdis dropped", v, 8'h00);
    rd(8, v); rd(8, v);
    // R10 test set
    wr(15, 8'h08);
    rd(9, v);  chk("R10 test set bank1", v, 8'h08);
    rd(5, v);  chk("R10 bank0 untouched", v, 8'h00);
    rd(15, v); chk("R10 test reads zero", v, 8'h00);
    // R11 clear and event collide
    wr(0, 8'h02);
    wr(1, 8'h10);
    wr(12, 8'h04);
    @(negedge clk); src_i[2] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = AW'(4); wdata = 8'h04;
    @(negedge clk); wr_en = 0;
    rd(4, v);  chk("R11 event wins", v, 8'h04);
    wr(4, 8'h04);
    rd(4, v);  chk("R7 plain clear", v, 8'h00);
    wr(10, 8'hFB); idle(1);
    chk("R6 bank1 low only", {6'b0, irq_n}, 8'h01);
    // R12 edge kept, idle read zero
    rd(1, v);  chk("R12 edge retained", v, 8'h10);
    idle(1);
    chk("R12 idle rdata", rdata, 8'h00);
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule